// File: doc/BRIEF.md
# Iterative Multiply/Divide Register Unit

This block is a small arithmetic peripheral on a simple register bus. It computes either an unsigned 16 by 16 bit product or an unsigned 32 by 16 bit quotient and remainder. Software loads the operands through byte or halfword writes, then sets the start bit in the control register. The unit then steps one bit per clock and raises a one-cycle completion pulse when the result is ready.

A single 32-bit register A holds the first operand and later the result. It holds the multiplicand, or the dividend, on entry. On exit it holds the product or the full 32-bit quotient. A 16-bit register B holds the multiplier or the divisor. A separate read-only 16-bit register receives the remainder of a divide. While an operation runs, the unit drops writes to A, B and control, so the operands stay intact.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, registers A, B, the remainder and the control register read as zero, and done_o is low.
- R2: The byte addresses are as follows: A bytes 0 (least significant) to 3, B bytes 4 to 5, remainder bytes 6 to 7, control byte 8. With size_i=0 a write changes only the addressed byte from wdata_i[7:0], and a read returns that byte on rdata_o[7:0] with the upper bits zero. With size_i=1 the access covers the aligned halfword (address bit 0 ignored), with the lower-addressed byte on bits 7:0.
- R3: In multiply mode, with A[31:16] zero beforehand, A becomes A[15:0]*B. done_o is high in the sampling window of the 16th rising edge after the edge that captured the start write.
- R4: In divide mode with B nonzero, A becomes floor(A/B) as a full 32-bit quotient and the remainder register becomes A mod B. done_o is high after the 32nd rising edge following the start-capture edge.
- R5: In the control byte, bit 7 is start/busy and bit 0 selects the mode (1 multiply, 0 divide). Writing bit 7 as 1 while idle starts an operation and also latches bit 0. A write with bit 7 as 0 while idle only updates the mode. Bit 7 reads 1 while an operation runs and clears by itself at completion.
- R6: While busy, writes to A, B and the control byte are ignored: the result, the read-back value of B and the mode bit are unaffected.
- R7: A divide with B equal to zero still completes, with done_o after 32 cycles. The result values are unspecified.
- R8: Writes to the remainder register bytes are ignored.
- R9: done_o is a single-cycle pulse. It coincides with busy having just cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Byte address of the access |
| size_i | input | 1 | Access size: 0 byte, 1 halfword |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; rdata_o is zero when low |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from address |
| done_o | output | 1 | One-cycle pulse at completion of an operation |

## Verification
The multiply is swept over a full cross product of edge values (zero, one, two, byte and halfword boundaries, 0x7FFF, 0x8000, all ones), which separates carry propagation faults in the shift-add path from lost shifts. The divide is swept over 32-bit edge dividends crossed with nonzero edge divisors. These include quotients wider than 16 bits and divisors larger than the dividend, and they show whether the trial subtraction keeps its extra bit. Random operands for both modes follow. Directed cases cover byte-lane writes, writes during a running operation, writes to the remainder register, and a zero divisor. Each case has an exact cycle count for done_o.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    MODE_DIV = 1'b0,
    MODE_MUL = 1'b1
  } mode_e;

  localparam int unsigned CTRL_START_BIT = 7;
  localparam int unsigned CTRL_MODE_BIT  = 0;
endpackage

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int unsigned OP_W = 16,
  localparam int unsigned AW  = 2 * OP_W
) (
  input  muldiv_pkg::mode_e mode_i,
  input  logic [AW-1:0]     a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic [OP_W-1:0]   r_i,
  output logic [AW-1:0]     a_o,
  output logic [OP_W-1:0]   r_o
);
  logic [OP_W:0] mul_sum;
  logic [OP_W:0] trial;
  logic [OP_W:0] diff;
  logic          ge;

  // shift-add: upper half accumulates, whole register shifts right
  assign mul_sum = a_i[0] ? ({1'b0, a_i[AW-1:OP_W]} + {1'b0, b_i})
                          : {1'b0, a_i[AW-1:OP_W]};

  // restoring shift-subtract: quotient bits shift in from the right
  assign trial = {r_i, a_i[AW-1]};
  assign diff  = trial - {1'b0, b_i};
  assign ge    = (trial >= {1'b0, b_i});

  always_comb begin
    if (mode_i == muldiv_pkg::MODE_MUL) begin
      a_o = {mul_sum, a_i[OP_W-1:1]};
      r_o = r_i;
    end else begin
      a_o = {a_i[AW-2:0], ge};
      r_o = ge ? diff[OP_W-1:0] : trial[OP_W-1:0];
    end
  end
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CTRL_A = 8,
  localparam int unsigned MUL_STEPS = OP_W,
  localparam int unsigned DIV_STEPS = 2 * OP_W,
  localparam int unsigned CNT_W     = $clog2(DIV_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wbyte_i,
  output logic              busy_o,
  output muldiv_pkg::mode_e mode_o,
  output logic              clr_rem_o,
  output logic              done_o
);
  import muldiv_pkg::*;

  logic             ctrl_hit;
  logic             start;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign ctrl_hit  = wr_i && (addr_i == ADDR_W'(CTRL_A)) && !busy_o;
  assign start     = ctrl_hit && wbyte_i[CTRL_START_BIT];
  assign clr_rem_o = start && (wbyte_i[CTRL_MODE_BIT] == MODE_DIV);
  assign last      = (mode_o == MODE_MUL) ? CNT_W'(MUL_STEPS - 1) : CNT_W'(DIV_STEPS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      mode_o <= MODE_DIV;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (ctrl_hit) mode_o <= mode_e'(wbyte_i[CTRL_MODE_BIT]);
      if (start) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_o) begin
        if (cnt_q == last) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= last)); // R3
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mode_o)); // R6
endmodule

// File: rtl/muldiv_regs.sv
module muldiv_regs #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned AW  = 2 * OP_W,
  localparam int unsigned WB  = OP_W / 8,
  localparam int unsigned WBL = (WB > 1) ? $clog2(WB) : 1,
  localparam int unsigned LA  = AW / 8,
  localparam int unsigned NB  = LA + WB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OP_W-1:0]   wdata_i,
  input  logic              lock_i,
  input  muldiv_pkg::mode_e mode_i,
  input  logic              ld_i,
  input  logic              r_clr_i,
  input  logic [AW-1:0]     a_nxt_i,
  input  logic [OP_W-1:0]   r_nxt_i,
  output logic [AW-1:0]     a_o,
  output logic [OP_W-1:0]   b_o,
  output logic [OP_W-1:0]   r_o
);
  logic [NB-1:0] hit;
  logic [7:0]    dat [NB];
  logic [AW-1:0]   a_d;
  logic [OP_W-1:0] b_d;
  logic [OP_W-1:0] r_d;

  for (genvar j = 0; j < NB; j++) begin : g_lane
    localparam logic [ADDR_W-1:0] LADR = ADDR_W'(j);
    assign hit[j] = size_i ? (addr_i[ADDR_W-1:WBL] == LADR[ADDR_W-1:WBL])
                           : (addr_i == LADR);
    assign dat[j] = size_i ? wdata_i[8*(j%WB)+:8] : wdata_i[7:0];
  end

  always_comb begin
    a_d = a_o;
    b_d = b_o;
    if (wr_i && !lock_i) begin
      for (int j = 0; j < LA; j++)
        if (hit[j]) a_d[8*j+:8] = dat[j];
      for (int j = 0; j < WB; j++)
        if (hit[LA+j]) b_d[8*j+:8] = dat[LA+j];
    end
    if (ld_i) a_d = a_nxt_i;
  end

  always_comb begin
    r_d = r_o;
    if (r_clr_i)   r_d = '0;
    else if (ld_i) r_d = r_nxt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o <= '0;
      b_o <= '0;
      r_o <= '0;
    end else begin
      a_o <= a_d;
      b_o <= b_d;
      r_o <= r_d;
    end
  end

  AST_B_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(b_o)); // R6
  AST_REM_BELOW_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && mode_i == muldiv_pkg::MODE_DIV && b_o != '0) |-> (r_o < b_o)); // R4
  AST_REM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && !r_clr_i) |=> $stable(r_o)); // R8
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [OP_W-1:0]   wdata_i,
  output logic [OP_W-1:0]   rdata_o,
  output logic              done_o
);
  import muldiv_pkg::*;

  localparam int unsigned AW     = 2 * OP_W;
  localparam int unsigned WB     = OP_W / 8;
  localparam int unsigned WBL    = (WB > 1) ? $clog2(WB) : 1;
  localparam int unsigned CTRL_A = AW / 8 + 2 * WB;
  localparam int unsigned NTOT   = CTRL_A + WB;

  logic [AW-1:0]   a_q, a_nxt;
  logic [OP_W-1:0] b_q, r_q, r_nxt;
  logic            busy, clr_rem;
  mode_e           mode;
  logic [8*NTOT-1:0] flat;

  muldiv_ctrl #(.OP_W(OP_W), .ADDR_W(ADDR_W), .CTRL_A(CTRL_A)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wbyte_i   (wdata_i[7:0]),
    .busy_o    (busy),
    .mode_o    (mode),
    .clr_rem_o (clr_rem),
    .done_o    (done_o)
  );

  muldiv_step #(.OP_W(OP_W)) u_step (
    .mode_i (mode),
    .a_i    (a_q),
    .b_i    (b_q),
    .r_i    (r_q),
    .a_o    (a_nxt),
    .r_o    (r_nxt)
  );

  muldiv_regs #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .size_i  (size_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .lock_i  (busy),
    .mode_i  (mode),
    .ld_i    (busy),
    .r_clr_i (clr_rem),
    .a_nxt_i (a_nxt),
    .r_nxt_i (r_nxt),
    .a_o     (a_q),
    .b_o     (b_q),
    .r_o     (r_q)
  );

  always_comb begin
    flat = '0;
    flat[AW-1:0]            = a_q;
    flat[AW+:OP_W]          = b_q;
    flat[AW+OP_W+:OP_W]     = r_q;
    flat[8*CTRL_A+CTRL_START_BIT] = busy;
    flat[8*CTRL_A+CTRL_MODE_BIT]  = mode;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      for (int j = 0; j < NTOT; j++) begin
        if (size_i) begin
          if (addr_i[ADDR_W-1:WBL] == (ADDR_W-WBL)'(j / WB))
            rdata_o[8*(j%WB)+:8] = flat[8*j+:8];
        end else if (addr_i == ADDR_W'(j)) begin
          rdata_o[7:0] = flat[8*j+:8];
        end
      end
    end
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0)); // R2
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        size = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  muldiv_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d, input logic sz);
    @(negedge clk);
    addr = a; wdata = d; size = sz; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic sz, output logic [15:0] d);
    @(negedge clk);
    addr = a; size = sz; rd = 1'b1;
    #2 d = rdata;
    rd = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
    if (!done) chk("watchdog done", 32'h0, 32'h1);
  endtask

  task automatic run_op(input logic mul, input logic [31:0] a, input logic [15:0] b,
                        output logic [31:0] res, output logic [15:0] rem, output int cyc);
    logic [15:0] lo, hi;
    bus_wr(4'd0, a[15:0], 1'b1);
    bus_wr(4'd2, a[31:16], 1'b1);
    bus_wr(4'd4, b, 1'b1);
    bus_wr(4'd8, {8'h0, 7'h40, mul}, 1'b0);
    wait_done(cyc);
    @(negedge clk);
    chk("R9 done single pulse", {31'h0, done}, 32'h0);
    bus_rd(4'd0, 1'b1, lo);
    bus_rd(4'd2, 1'b1, hi);
    bus_rd(4'd6, 1'b1, rem);
    res = {hi, lo};
  endtask

  task automatic do_mul(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] res; logic [15:0] rem; int cyc;
    run_op(1'b1, {16'h0, a}, b, res, rem, cyc);
    chk("R3 product", res, 32'(a) * 32'(b));
    chk("R3 latency", 32'(cyc), 32'd16);
  endtask

  task automatic do_div(input logic [31:0] a, input logic [15:0] b);
    logic [31:0] res; logic [15:0] rem; int cyc;
    run_op(1'b0, a, b, res, rem, cyc);
    chk("R4 quotient", res, a / 32'(b));
    chk("R4 remainder", {16'h0, rem}, a % 32'(b));
    chk("R4 latency", 32'(cyc), 32'd32);
  endtask

  initial begin
    #(20 * 150000);
    chk("watchdog global", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [31:0] res;
    logic [15:0] rem;
    int cyc;
    logic [15:0] mv [9];
    logic [31:0] dv [8];
    logic [15:0] sv [7];
    mv = '{16'h0, 16'h1, 16'h2, 16'hFF, 16'h100, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
    dv = '{32'h0, 32'h1, 32'hFFFF, 32'h10000, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12345678};
    sv = '{16'h1, 16'h2, 16'h3, 16'hFF, 16'h8000, 16'hFFFE, 16'hFFFF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 5; k++) begin
      bus_rd(4'(2 * k), 1'b1, d);
      chk("R1 reset value", {16'h0, d}, 32'h0);
    end
    chk("R1 done low", {31'h0, done}, 32'h0);

    // R2 byte lanes
    bus_wr(4'd0, 16'h0011, 1'b0);
    bus_wr(4'd1, 16'h0022, 1'b0);
    bus_wr(4'd2, 16'h0033, 1'b0);
    bus_wr(4'd3, 16'h0044, 1'b0);
    bus_rd(4'd0, 1'b1, d); chk("R2 A low half", {16'h0, d}, 32'h2211);
    bus_rd(4'd3, 1'b1, d); chk("R2 A high half", {16'h0, d}, 32'h4433);
    bus_rd(4'd2, 1'b0, d); chk("R2 A byte2", {16'h0, d}, 32'h33);
    bus_wr(4'd4, 16'hBEEF, 1'b1);
    bus_wr(4'd5, 16'h00AB, 1'b0);
    bus_rd(4'd4, 1'b1, d); chk("R2 B byte5 merge", {16'h0, d}, 32'hABEF);
    bus_rd(4'd4, 1'b0, d); chk("R2 B byte4", {16'h0, d}, 32'hEF);

    // R5 mode-only write
    bus_wr(4'd8, 16'h0001, 1'b0);
    bus_rd(4'd8, 1'b0, d); chk("R5 mode only", {16'h0, d}, 32'h01);
    chk("R5 no start", {31'h0, done}, 32'h0);

    // R3 multiply sweep
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        do_mul(mv[i], mv[j]);
    for (int k = 0; k < 150; k++)
      do_mul(16'($urandom), 16'($urandom));

    // R4 divide sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 7; j++)
        do_div(dv[i], sv[j]);
    for (int k = 0; k < 150; k++) begin
      logic [15:0] bb;
      bb = 16'($urandom);
      if (bb == 16'h0) bb = 16'h1;
      do_div($urandom, bb);
    end

    // R7 zero divisor completes
    run_op(1'b0, 32'h12345678, 16'h0, res, rem, cyc);
    chk("R7 zero divisor latency", 32'(cyc), 32'd32);

    // R8 remainder read-only
    do_div(32'd1000, 16'd7);
    bus_wr(4'd6, 16'h1234, 1'b1);
    bus_wr(4'd7, 16'h0055, 1'b0);
    bus_rd(4'd6, 1'b1, d); chk("R8 remainder unchanged", {16'h0, d}, 32'd6);

    // R5 busy bit and R6 writes ignored while busy
    bus_wr(4'd0, 16'd300, 1'b1);
    bus_wr(4'd2, 16'd0, 1'b1);
    bus_wr(4'd4, 16'd211, 1'b1);
    bus_wr(4'd8, 16'h0081, 1'b0);
    bus_rd(4'd8, 1'b0, d); chk("R5 busy reads set", {16'h0, d}, 32'h81);
    bus_wr(4'd0, 16'hFFFF, 1'b1);
    bus_wr(4'd4, 16'h7777, 1'b1);
    bus_wr(4'd8, 16'h0080, 1'b0);
    wait_done(cyc);
    bus_rd(4'd0, 1'b1, res[15:0]);
    bus_rd(4'd2, 1'b1, res[31:16]);
    chk("R6 product intact", res, 32'd63300);
    bus_rd(4'd4, 1'b1, d); chk("R6 B intact", {16'h0, d}, 32'd211);
    bus_rd(4'd8, 1'b0, d); chk("R5 R6 idle mode kept", {16'h0, d}, 32'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule